// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block gathers level-sensitive hardware interrupt lines and two software-raised interrupt bits into one pending vector. It gates that vector with a per-source enable mask and a global enable, and signals the processor when any enabled source is pending. It presents the index of the most urgent enabled source on the same cycle, so the handler can dispatch without scanning.

Software reaches two words through a small register port. The status word holds the per-source mask and the global enable. The cause word shows the pending vector, and its two lowest bits can be set or cleared by software. When the processor signals handler entry, the block pushes the current mask onto an internal LIFO. It then narrows the mask so that only sources strictly above the serviced one stay enabled, and it leaves the global enable set so that more urgent sources can preempt the handler. A return pulse pops the LIFO and reinstates the mask that was active before the matching entry. Because the LIFO is several entries deep, handlers can nest.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mask is 0, the global enable is 0, both software pending bits are 0, the save stack is empty, and `irq_out` is 0.
- R2: `irq_out` is 1 exactly when the global enable is 1 and at least one bit is set in both the pending vector and the mask.
- R3: `irq_id` gives, on the same cycle, the index of the highest set bit of (pending AND mask). Bit 7 is the most urgent and bit 0 the least. The global enable does not affect `irq_id`, and `irq_id` is 0 when no such bit is set.
- R4: Pending bits 7..2 follow `hw_req[5:0]` combinationally, with `hw_req[k]` driving pending bit k+2. Reading the cause word (`reg_addr`=1) returns the pending vector in bits 7..0 and zeros above.
- R5: A write to the cause word loads `reg_wdata[1:0]` into software pending bits 1..0. Every other bit of that write has no effect.
- R6: A write to the status word (`reg_addr`=0) loads the mask from `reg_wdata[7:0]` and the global enable from `reg_wdata[8]`. Reading the status word returns {enable, mask} in bits 8..0.
- R7: An entry pulse taken while `irq_out` is 1 saves the current mask on the stack. It clears mask bits `irq_id` down to 0, keeps the bits above `irq_id`, and sets the global enable to 1.
- R8: An entry pulse is ignored when `irq_out` is 0 or when the stack already holds DEPTH (8) masks.
- R9: A return pulse restores the most recently saved mask and leaves the global enable unchanged. A return pulse with an empty stack has no effect.
- R10: A return pulse takes precedence over a same-cycle entry pulse, which is then ignored. A taken entry or return discards a same-cycle status write.
- R11: Up to 8 nested entries are saved, and the saved masks come back in reverse order of entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req | input | 6 | Level-sensitive hardware requests, hw_req[k] is pending bit k+2 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 cause |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data of the selected register |
| enter | input | 1 | Handler entry pulse |
| leave | input | 1 | Handler return pulse |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_id | output | 3 | Index of the most urgent enabled pending source |

## Verification
The priority encoder is driven with a table of pending, mask and enable combinations. The table separates the lone software bit, both software bits together, a hardware bit outranking software bits, a high source hidden by its mask so a lower one wins, and a cleared global enable that silences the request while the index still resolves. Directed sequences then nest two entries at different levels and unwind them, checking both that the narrowed mask hides the serviced level and that a higher source still breaks through. Further sequences fill the save stack to its limit with distinct masks, so that a reversed or truncated restore order shows up, and drive entry, return and status writes in the same cycle to check which of them wins.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared register selection type for the interrupt controller.
// Assumes a single-bit register address space.
package irq_pkg;
    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_CAUSE  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_pend.sv
// Module irq_pend
// Builds the pending vector: upper bits mirror hardware request levels,
// lowest NSW bits are software-held flags loaded by a register write.
// Assumes requests are already synchronous to clk.
module irq_pend #(
    parameter int unsigned NSRC = 8,
    parameter int unsigned NSW  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-NSW-1:0]  hw_req,
    input  logic                 sw_wr,
    input  logic [NSW-1:0]       sw_wdata,
    output logic [NSRC-1:0]      pend
);
    logic [NSW-1:0] sw_q;

    // Software pending flags: cleared on reset, loaded by cause writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else if (sw_wr) begin
            sw_q <= sw_wdata;
        end
    end

    // Concatenate level-following hardware bits above software bits.
    always_comb begin
        pend = {hw_req, sw_q};
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Module irq_prio_enc
// Priority encoder: highest set index wins. Reports zero when nothing set.
// Assumes N is a power of two or at least 2.
module irq_prio_enc #(
    parameter int unsigned N = 8,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] id
);
    // Scan upward so the last (highest) set bit overrides lower ones.
    always_comb begin
        id = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                id = IW'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/irq_mask_stack.sv
// Module irq_mask_stack
// LIFO holding saved masks across nested handler entries.
// Assumes the caller never pushes when full nor pops when empty.
module irq_mask_stack #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] count;

    // Occupancy counter: push grows, pop shrinks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (pop) begin
            count <= count - CW'(1);
        end else if (push) begin
            count <= count + CW'(1);
        end
    end

    // Storage write at the current free slot.
    always_ff @(posedge clk) begin
        if (push && !pop) begin
            mem[PW'(count)] <= din;
        end
    end

    // Top-of-stack view and occupancy flags.
    always_comb begin
        empty = (count == '0);
        full  = (count == CW'(DEPTH));
        top   = empty ? '0 : mem[PW'(count - CW'(1))];
    end

    // R11: the caller must never push past the last slot.
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9: the caller must never pop an empty stack.
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module irq_prio_ctrl
// Priority-level maskable interrupt controller. Combines pending and mask,
// raises irq_out under a global enable, and on handler entry saves the mask
// and narrows it to strictly higher sources; return restores it.
// Assumes enter/leave are single-cycle pulses from the processor.
module irq_prio_ctrl #(
    parameter int unsigned NSRC  = 8,
    parameter int unsigned NSW   = 2,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 16,
    localparam int unsigned IW   = $clog2(NSRC),
    localparam int unsigned NHW  = NSRC - NSW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NHW-1:0]  hw_req,
    input  logic            reg_wr,
    input  logic            reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            enter,
    input  logic            leave,
    output logic            irq_out,
    output logic [IW-1:0]   irq_id
);
    import irq_pkg::*;

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] mask_q;
    logic            gie_q;
    logic [NSRC-1:0] enabled;
    logic            any_en;
    logic [NSRC-1:0] keep_hi;
    logic [NSRC-1:0] stk_top;
    logic            stk_full;
    logic            stk_empty;
    logic            take_enter;
    logic            take_leave;
    logic            wr_status;
    logic            wr_cause;
    logic            unused_wdata;

    assign unused_wdata = ^reg_wdata[DW-1:NSRC+1];

    // Decode register writes by address.
    always_comb begin
        wr_status = reg_wr && (reg_addr == REG_STATUS);
        wr_cause  = reg_wr && (reg_addr == REG_CAUSE);
    end

    irq_pend #(.NSRC(NSRC), .NSW(NSW)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_req   (hw_req),
        .sw_wr    (wr_cause),
        .sw_wdata (reg_wdata[NSW-1:0]),
        .pend     (pend)
    );

    // Gate pending sources with their mask bits.
    always_comb begin
        enabled = pend & mask_q;
    end

    irq_prio_enc #(.N(NSRC)) u_enc (
        .req (enabled),
        .any (any_en),
        .id  (irq_id)
    );

    // Request the processor only under the global enable.
    always_comb begin
        irq_out = gie_q && any_en;
    end

    // Per-bit keep mask: only sources strictly above the serviced one survive.
    for (genvar g = 0; g < NSRC; g++) begin : g_keep
        assign keep_hi[g] = (g > int'(irq_id));
    end

    // Arbitrate entry and return; return wins a tie.
    always_comb begin
        take_leave = leave && !stk_empty;
        take_enter = enter && !leave && irq_out && !stk_full;
    end

    irq_mask_stack #(.W(NSRC), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take_enter),
        .pop   (take_leave),
        .din   (mask_q),
        .top   (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    // Status register: mask and global enable, updated by entry/return/write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            gie_q  <= 1'b0;
        end else if (take_leave) begin
            mask_q <= stk_top;
        end else if (take_enter) begin
            mask_q <= mask_q & keep_hi;
            gie_q  <= 1'b1;
        end else if (wr_status) begin
            mask_q <= reg_wdata[NSRC-1:0];
            gie_q  <= reg_wdata[NSRC];
        end
    end

    // Read mux for the two register words.
    always_comb begin
        if (reg_addr == REG_STATUS) begin
            reg_rdata = DW'({gie_q, mask_q});
        end else begin
            reg_rdata = DW'(pend);
        end
    end

    // R2: no request without the global enable.
    a_r2_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> gie_q);

    // R3: the reported index names an enabled pending source with none above it.
    a_r3_id_is_top: assert property (@(posedge clk) disable iff (!rst_n)
        any_en |-> ((enabled >> irq_id) == NSRC'(1)));

    // R7: an accepted entry narrows the mask and re-enables globally.
    a_r7_entry_narrows: assert property (@(posedge clk) disable iff (!rst_n)
        take_enter |=> (gie_q && mask_q == ($past(mask_q) & $past(keep_hi))));

    // R9: an accepted return reinstates the saved mask and keeps the enable.
    a_r9_restore: assert property (@(posedge clk) disable iff (!rst_n)
        take_leave |=> (mask_q == $past(stk_top) && gie_q == $past(gie_q)));

    // R8: an entry without a request leaves the status unchanged.
    a_r8_ignore_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && !leave && !irq_out && !reg_wr) |=> $stable(mask_q));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  hw_req = '0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        enter = 1'b0;
    logic        leave = 1'b0;
    logic        irq_out;
    logic [2:0]  irq_id;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_req    (hw_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .enter     (enter),
        .leave     (leave),
        .irq_out   (irq_out),
        .irq_id    (irq_id)
    );

    // Vector: {hw_req[5:0], mask[7:0], gie, sw[1:0], exp_irq, exp_id[2:0]}
    localparam logic [20:0] VEC [0:7] = '{
        {6'h00, 8'hFF, 1'b1, 2'b00, 1'b0, 3'd0},
        {6'h00, 8'hFF, 1'b1, 2'b01, 1'b1, 3'd0},
        {6'h00, 8'hFF, 1'b1, 2'b11, 1'b1, 3'd1},
        {6'h01, 8'hFF, 1'b1, 2'b11, 1'b1, 3'd2},
        {6'h20, 8'h7F, 1'b1, 2'b00, 1'b0, 3'd0},
        {6'h21, 8'h7F, 1'b1, 2'b00, 1'b1, 3'd2},
        {6'h3F, 8'hFF, 1'b0, 2'b11, 1'b0, 3'd7},
        {6'h0A, 8'h08, 1'b1, 2'b10, 1'b1, 3'd3}
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input logic e, input logic l, input logic w,
                       input logic a, input logic [15:0] d);
        @(negedge clk);
        enter = e; leave = l; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        enter = 1'b0; leave = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, d); chk("R1 status after reset", d, 16'h0000);
        rd(1'b1, d); chk("R1 cause after reset", d, 16'h0000);
        chk("R1 irq_out after reset", {15'b0, irq_out}, 16'h0000);

        // R2 R3 R4 R5 R6 table walk
        for (int i = 0; i < 8; i++) begin
            hw_req = VEC[i][20:15];
            cyc(1'b0, 1'b0, 1'b1, 1'b0, {7'b0, VEC[i][6], VEC[i][14:7]});
            cyc(1'b0, 1'b0, 1'b1, 1'b1, {14'b0, VEC[i][5:4]});
            #1;
            chk("R2 irq_out vector", {15'b0, irq_out}, {15'b0, VEC[i][3]});
            chk("R3 irq_id vector", {13'b0, irq_id}, {13'b0, VEC[i][2:0]});
            rd(1'b1, d); chk("R4 cause readback", d, {8'b0, VEC[i][20:15], VEC[i][5:4]});
            rd(1'b0, d); chk("R6 status readback", d, {7'b0, VEC[i][6], VEC[i][14:7]});
        end

        // R5 upper cause bits ignored
        hw_req = '0;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFC);
        rd(1'b1, d); chk("R5 cause upper bits ignored", d, 16'h0000);

        // R7 nested entry and R9 unwind
        hw_req = 6'b001000;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 16'h0002);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 16'h01FF);
        #1;
        chk("R7 pre-entry id", {13'b0, irq_id}, 16'd5);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        rd(1'b0, d); chk("R7 mask after entry", d, 16'h01C0);
        chk("R7 serviced level hidden", {15'b0, irq_out}, 16'h0000);
        hw_req = 6'b101000;
        #1;
        chk("R7 higher source nests", {15'b0, irq_out}, 16'h0001);
        chk("R7 higher source id", {13'b0, irq_id}, 16'd7);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        rd(1'b0, d); chk("R7 second entry", d, 16'h0100);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
        rd(1'b0, d); chk("R9 first return", d, 16'h01C0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
        rd(1'b0, d); chk("R9 second return", d, 16'h01FF);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
        rd(1'b0, d); chk("R9 return on empty", d, 16'h01FF);

        // R8 entry ignored without request
        hw_req = '0;
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 16'h00FF);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        rd(1'b0, d); chk("R8 entry ignored when idle", d, 16'h00FF);

        // R10 precedence
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 16'h0001);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 16'h01FF);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 16'h0155);
        rd(1'b0, d); chk("R10 entry beats status write", d, 16'h01FE);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 16'h01FF);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
        rd(1'b0, d); chk("R10 return beats entry", d, 16'h01FF);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 16'h0103);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
        rd(1'b0, d); chk("R10 tied entry not saved", d, 16'h0103);

        // R11 fill to depth, overflow ignored, reverse unwind
        for (int k = 0; k < 8; k++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b0, 16'h0100 | 16'(k << 4) | 16'h1);
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
            rd(1'b0, d); chk("R11 push level", d, 16'h0100 | 16'(k << 4));
        end
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 16'h01FF);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        rd(1'b0, d); chk("R8 entry ignored when full", d, 16'h01FF);
        for (int j = 0; j < 8; j++) begin
            cyc(1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
            rd(1'b0, d); chk("R11 pop order", d, 16'h0100 | 16'((7 - j) << 4) | 16'h1);
        end
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
        rd(1'b0, d); chk("R9 pop past bottom", d, 16'h0101);

        // R1 reset clears a busy state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(1'b0, d); chk("R1 status after second reset", d, 16'h0000);
        rd(1'b1, d); chk("R1 cause after second reset", d, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule